// File: doc/BRIEF.md
# Typed Boundary Scan Register

This block sits between a chip's core logic and its pad ring. It puts a serial scan register on the signals of a fixed set of pins, so that a test controller can observe and drive each pin. Each pin has one of four kinds: input only, output only, tristate output, or bidirectional. The kind sets how many scan bits the pin occupies. The pin list and the kinds are parameters. The chain is built from them when the design is elaborated, so each pin lands at a fixed bit offset.

Three data-register strobes drive the chain: capture, shift and update. They come from an external test access port controller, whose state machine and instruction decoding are not part of this block. The test clock clocks the chain. Capture loads the chain from the live pin signals. Shift moves the chain one bit per clock, from the serial input toward the serial output. Update copies the chain into a parallel hold register. A mode input selects what the pins see. When it is low, core and pad are wired straight through. When it is high, the hold register drives the pad outputs, the pad enables and the core-facing inputs.

Top module: `tbs_top`

## Requirements
- R1: Scan bits per pin are 1 for input-only (kind code 0), 1 for output-only (code 1), 2 for tristate output (code 2) and 3 for bidirectional (code 3). The chain length is the sum over all pins; the default set {in, out, tri, bidir, bidir, in} gives 11 bits.
- R2: Pin p's first bit sits at the sum of the scan lengths of pins 0..p-1. Within a pin, the fields run upward from that offset in the order: input, output, output-enable (only the fields its kind has).
- R3: On capture, input fields load the pad input. Output and enable fields load the core-side output and enable.
- R4: On shift, the serial input enters the top bit and every bit moves down by one. The serial output is bit 0 of the chain, taken from a register.
- R5: The hold register changes only on update. Shifting and capturing leave all pin values unchanged.
- R6: With mode low, pad output and pad enable follow the core-side output and enable. Core-side input follows the pad input, all combinationally.
- R7: With mode high, pad output and pad enable come from the hold register fields, and so does the core-side input.
- R8: An output-only pin always has its pad enable at 1. An input-only pin holds its pad output and pad enable at 0. A pin with no input field holds its core-side input at 0.
- R9: After reset, the chain and the hold register are all zero, so the serial output is 0.
- R10: When strobes coincide, capture wins over shift and shift wins over update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift strobe |
| updateDr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| testMode | input | 1 | 0 = straight-through wiring, 1 = hold register drives the pins |
| corOut | input | NUM_PINS | Core-side output value per pin |
| corOe | input | NUM_PINS | Core-side output enable per pin |
| corIn | output | NUM_PINS | Input value delivered to the core per pin |
| padIn | input | NUM_PINS | Value received from the pad per pin |
| padOut | output | NUM_PINS | Value driven to the pad per pin |
| padOe | output | NUM_PINS | Pad output enable per pin |

## Verification
The assertions assume the strobes are synchronous to the test clock and held for whole cycles. They assume pad and core inputs change only away from the rising edge. In test mode, the frozen-pin property also assumes that nothing else changes mode during the checked cycle. The bench changes every input on the falling edge. It raises strobes together only in the directed priority cases, and it keeps the random pin values constant throughout each capture, scan and update sequence.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  localparam int MAX_PINS = 64;

  localparam logic [1:0] KIND_IN    = 2'd0;
  localparam logic [1:0] KIND_OUT   = 2'd1;
  localparam logic [1:0] KIND_TRI   = 2'd2;
  localparam logic [1:0] KIND_BIDIR = 2'd3;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } scanStrobes_t;

  function automatic int kindLen(input logic [1:0] kind);
    case (kind)
      KIND_IN, KIND_OUT: return 1;
      KIND_TRI:          return 2;
      default:           return 3;
    endcase
  endfunction

  // running sum of lengths of all pins below `pin`
  function automatic int pinOffset(input logic [2*MAX_PINS-1:0] kinds, input int pin);
    int acc;
    acc = 0;
    for (int p = 0; p < MAX_PINS; p++)
      if (p < pin) acc += kindLen(kinds[2*p +: 2]);
    return acc;
  endfunction

  function automatic logic [MAX_PINS-1:0] inputMask(input logic [2*MAX_PINS-1:0] kinds,
                                                     input int numPins);
    logic [MAX_PINS-1:0] m;
    m = '0;
    for (int p = 0; p < MAX_PINS; p++)
      if (p < numPins && (kinds[2*p +: 2] == KIND_IN || kinds[2*p +: 2] == KIND_BIDIR))
        m[p] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tbs_ctrl.sv
module tbs_ctrl
  import tbs_pkg::*;
(
  input  logic         captureDr,
  input  logic         shiftDr,
  input  logic         updateDr,
  output scanStrobes_t strobes
);
  // capture beats shift, shift beats update (R10)
  always_comb begin
    strobes.capture = captureDr;
    strobes.shift   = shiftDr & ~captureDr;
    strobes.update  = updateDr & ~captureDr & ~shiftDr;
  end
endmodule

// File: rtl/tbs_datapath.sv
module tbs_datapath
  import tbs_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 12'b00_11_11_10_01_00,
  parameter int CHAIN_LEN = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobes_t         strobes,
  input  logic                 tdi,
  input  logic                 testMode,
  input  logic [NUM_PINS-1:0]  corOut,
  input  logic [NUM_PINS-1:0]  corOe,
  input  logic [NUM_PINS-1:0]  padIn,
  output logic [NUM_PINS-1:0]  corIn,
  output logic [NUM_PINS-1:0]  padOut,
  output logic [NUM_PINS-1:0]  padOe,
  output logic [CHAIN_LEN-1:0] shiftState,
  output logic [CHAIN_LEN-1:0] holdState
);
  localparam logic [2*MAX_PINS-1:0] KINDS_EXT = (2*MAX_PINS)'(PIN_KINDS);

  logic [CHAIN_LEN-1:0] capVec;
  logic [CHAIN_LEN-1:0] shiftReg;
  logic [CHAIN_LEN-1:0] holdReg;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int OFF = pinOffset(KINDS_EXT, i);
    localparam logic [1:0] KIND = PIN_KINDS[2*i +: 2];
    if (KIND == KIND_IN) begin : g_in
      assign capVec[OFF] = padIn[i];
      assign corIn[i]    = testMode ? holdReg[OFF] : padIn[i];
      assign padOut[i]   = 1'b0;
      assign padOe[i]    = 1'b0;
    end else if (KIND == KIND_OUT) begin : g_out
      assign capVec[OFF] = corOut[i];
      assign corIn[i]    = 1'b0;
      assign padOut[i]   = testMode ? holdReg[OFF] : corOut[i];
      assign padOe[i]    = 1'b1;
    end else if (KIND == KIND_TRI) begin : g_tri
      assign capVec[OFF]   = corOut[i];
      assign capVec[OFF+1] = corOe[i];
      assign corIn[i]      = 1'b0;
      assign padOut[i]     = testMode ? holdReg[OFF]   : corOut[i];
      assign padOe[i]      = testMode ? holdReg[OFF+1] : corOe[i];
    end else begin : g_bidir
      assign capVec[OFF]   = padIn[i];
      assign capVec[OFF+1] = corOut[i];
      assign capVec[OFF+2] = corOe[i];
      assign corIn[i]      = testMode ? holdReg[OFF]   : padIn[i];
      assign padOut[i]     = testMode ? holdReg[OFF+1] : corOut[i];
      assign padOe[i]      = testMode ? holdReg[OFF+2] : corOe[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdReg  <= '0;
    end else begin
      if (strobes.capture)    shiftReg <= capVec;
      else if (strobes.shift) shiftReg <= {tdi, shiftReg[CHAIN_LEN-1:1]};
      if (strobes.update)     holdReg  <= shiftReg;
    end
  end

  assign shiftState = shiftReg;
  assign holdState  = holdReg;
endmodule

// File: rtl/tbs_top.sv
module tbs_top
  import tbs_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 12'b00_11_11_10_01_00
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                tdi,
  output logic                tdo,
  input  logic                testMode,
  input  logic [NUM_PINS-1:0] corOut,
  input  logic [NUM_PINS-1:0] corOe,
  output logic [NUM_PINS-1:0] corIn,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  localparam logic [2*MAX_PINS-1:0] KINDS_EXT = (2*MAX_PINS)'(PIN_KINDS);
  localparam int CHAIN_LEN = pinOffset(KINDS_EXT, NUM_PINS);

  scanStrobes_t         strobes;
  logic [CHAIN_LEN-1:0] shiftState;
  logic [CHAIN_LEN-1:0] holdState;

  tbs_ctrl ctrl_i (
    .captureDr(captureDr),
    .shiftDr  (shiftDr),
    .updateDr (updateDr),
    .strobes  (strobes)
  );

  tbs_datapath #(
    .NUM_PINS (NUM_PINS),
    .PIN_KINDS(PIN_KINDS),
    .CHAIN_LEN(CHAIN_LEN)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .tdi       (tdi),
    .testMode  (testMode),
    .corOut    (corOut),
    .corOe     (corOe),
    .padIn     (padIn),
    .corIn     (corIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .shiftState(shiftState),
    .holdState (holdState)
  );

  assign tdo = shiftState[0];
endmodule

// File: rtl/tbs_checker.sv
module tbs_checker
  import tbs_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 12'b00_11_11_10_01_00,
  parameter int CHAIN_LEN = 11
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 captureDr,
  input logic                 shiftDr,
  input logic                 updateDr,
  input logic                 tdi,
  input logic                 testMode,
  input logic [NUM_PINS-1:0]  corIn,
  input logic [NUM_PINS-1:0]  padIn,
  input logic [NUM_PINS-1:0]  padOut,
  input logic [NUM_PINS-1:0]  padOe,
  input logic [CHAIN_LEN-1:0] shiftState,
  input logic [CHAIN_LEN-1:0] holdState
);
  localparam logic [2*MAX_PINS-1:0] KINDS_EXT = (2*MAX_PINS)'(PIN_KINDS);
  localparam logic [MAX_PINS-1:0] IN_MASK_EXT = inputMask(KINDS_EXT, NUM_PINS);
  localparam logic [NUM_PINS-1:0] IN_MASK = IN_MASK_EXT[NUM_PINS-1:0];

  // R4: one-bit move toward bit 0 with tdi entering on top
  a_r4_shift_moves: assert property (@(posedge clk) disable iff (!rstN)
    (shiftDr && !captureDr) |=>
      (shiftState == {$past(tdi), $past(shiftState[CHAIN_LEN-1:1])}));

  // R5, R10: hold register moves only on an uncontested update
  a_r5_hold_only_on_update: assert property (@(posedge clk) disable iff (!rstN)
    (!updateDr || captureDr || shiftDr) |=> $stable(holdState));

  // R6: straight-through input path in functional mode
  a_r6_transparent_input: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (((corIn ^ padIn) & IN_MASK) == '0));

  // R7: pins frozen in test mode while no update happens
  a_r7_pins_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !updateDr) |=> (!testMode || ($stable(padOut) && $stable(padOe))));

  // R8: pins lacking an input field never feed the core
  a_r8_no_input_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((corIn & ~IN_MASK) == '0));
endmodule

bind tbs_top tbs_checker #(
  .NUM_PINS (NUM_PINS),
  .PIN_KINDS(PIN_KINDS),
  .CHAIN_LEN(CHAIN_LEN)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .captureDr (captureDr),
  .shiftDr   (shiftDr),
  .updateDr  (updateDr),
  .tdi       (tdi),
  .testMode  (testMode),
  .corIn     (corIn),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOe     (padOe),
  .shiftState(shiftState),
  .holdState (holdState)
);

// File: tb/tbs_top_tb_top.sv
`timescale 1ns/1ps
module tbs_top_tb_top;
  localparam int NP = 6;
  localparam int L  = 11;
  localparam logic [2*NP-1:0] KINDS = 12'b00_11_11_10_01_00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0, testMode = 1'b0;
  logic tdo;
  logic [NP-1:0] corOut = '0, corOe = '0, padIn = '0;
  logic [NP-1:0] corIn, padOut, padOe;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int kindOf[NP];
  int offOf[NP];

  always #10 clk = ~clk;

  tbs_top #(.NUM_PINS(NP), .PIN_KINDS(KINDS)) dut_i (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .testMode(testMode),
    .corOut(corOut), .corOe(corOe), .corIn(corIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lenOf(input int k);
    return (k == 3) ? 3 : (k == 2) ? 2 : 1;
  endfunction

  function automatic logic [L-1:0] capModel(input logic [NP-1:0] pi, co, coe);
    logic [L-1:0] v;
    v = '0;
    for (int p = 0; p < NP; p++) begin
      case (kindOf[p])
        0: v[offOf[p]] = pi[p];
        1: v[offOf[p]] = co[p];
        2: begin v[offOf[p]] = co[p]; v[offOf[p]+1] = coe[p]; end
        default: begin v[offOf[p]] = pi[p]; v[offOf[p]+1] = co[p]; v[offOf[p]+2] = coe[p]; end
      endcase
    end
    return v;
  endfunction

  function automatic logic [3*NP-1:0] pinModel(input logic [L-1:0] h, input logic m,
                                               input logic [NP-1:0] pi, co, coe);
    logic [NP-1:0] po, poe, ci;
    for (int p = 0; p < NP; p++) begin
      int o;
      o = offOf[p];
      case (kindOf[p])
        0: begin po[p] = 0; poe[p] = 0; ci[p] = m ? h[o] : pi[p]; end
        1: begin po[p] = m ? h[o] : co[p]; poe[p] = 1; ci[p] = 0; end
        2: begin po[p] = m ? h[o] : co[p]; poe[p] = m ? h[o+1] : coe[p]; ci[p] = 0; end
        default: begin
          ci[p] = m ? h[o] : pi[p]; po[p] = m ? h[o+1] : co[p]; poe[p] = m ? h[o+2] : coe[p];
        end
      endcase
    end
    return {ci, poe, po};
  endfunction

  task automatic checkPins(input string req, input logic [L-1:0] h);
    logic [3*NP-1:0] e;
    #1;
    e = pinModel(h, testMode, padIn, corOut, corOe);
    chk(req, 64'(padOut), 64'(e[NP-1:0]));
    chk(req, 64'(padOe),  64'(e[2*NP-1:NP]));
    chk(req, 64'(corIn),  64'(e[3*NP-1:2*NP]));
  endtask

  // called at a falling edge; returns there
  task automatic scanDr(input logic [L-1:0] din, output logic [L-1:0] dout);
    shiftDr = 1'b1;
    for (int k = 0; k < L; k++) begin
      tdi = din[k];
      dout[k] = tdo;
      @(negedge clk);
    end
    shiftDr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) captureDr = 1'b1; else updateDr = 1'b1;
    @(negedge clk);
    captureDr = 1'b0;
    updateDr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] hold, dout, din;
    int n;
    void'($urandom(32'd1234));
    kindOf = '{0, 1, 2, 3, 3, 0};
    offOf[0] = 0;
    for (int p = 1; p < NP; p++) offOf[p] = offOf[p-1] + lenOf(kindOf[p-1]);
    hold = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 tdo", 64'(tdo), 64'd0);
    testMode = 1'b1;
    checkPins("R9 hold zero", hold);
    chk("R8 out-only enable", 64'(padOe[1]), 64'd1);
    testMode = 1'b0;
    @(negedge clk);

    // R1: marker travels the whole chain
    shiftDr = 1'b1; tdi = 1'b1;
    @(negedge clk);
    tdi = 1'b0; n = 1;
    while (tdo !== 1'b1 && n < 40) begin @(negedge clk); n++; end
    shiftDr = 1'b0;
    chk("R1 chain length", 64'(n), 64'(L));
    chk("R1 total bits", 64'(offOf[NP-1] + lenOf(kindOf[NP-1])), 64'(L));
    scanDr('0, dout);
    pulse(1);

    // R2: one-hot in each pin's output field
    testMode = 1'b1;
    for (int p = 1; p < NP - 1; p++) begin
      int fo;
      fo = (kindOf[p] == 3) ? offOf[p] + 1 : offOf[p];
      din = '0; din[fo] = 1'b1;
      scanDr(din, dout);
      pulse(1);
      hold = din;
      #1;
      chk("R2 one-hot output field", 64'(padOut), 64'(1 << p));
      checkPins("R2 pins", hold);
    end
    testMode = 1'b0;

    // R10: capture over shift
    padIn = 6'b000001;
    captureDr = 1'b1; shiftDr = 1'b1; tdi = 1'b0;
    @(negedge clk);
    captureDr = 1'b0; shiftDr = 1'b0;
    chk("R10 capture wins", 64'(tdo), 64'd1);
    // R10: shift over update, hold untouched
    shiftDr = 1'b1; updateDr = 1'b1;
    @(negedge clk);
    shiftDr = 1'b0; updateDr = 1'b0;
    testMode = 1'b1;
    checkPins("R10 shift beats update", hold);
    testMode = 1'b0;

    // random rounds: R3 R4 R5 R6 R7 R8
    for (int it = 0; it < 40; it++) begin
      logic [L-1:0] expCap;
      padIn  = NP'($urandom);
      corOut = NP'($urandom);
      corOe  = NP'($urandom);
      din    = L'($urandom);
      if (it == 0) din = '1;
      if (it == 1) din = '0;
      expCap = capModel(padIn, corOut, corOe);
      @(negedge clk);
      pulse(0);
      testMode = 1'b1;
      scanDr(din, dout);
      chk("R3 R4 captured bits out", 64'(dout), 64'(expCap));
      checkPins("R5 pins steady during shift", hold);
      pulse(1);
      hold = din;
      checkPins("R7 test mode drive", hold);
      testMode = 1'b0;
      checkPins("R6 R8 transparent", hold);
      corOut = ~corOut; padIn = ~padIn; corOe = ~corOe;
      checkPins("R6 follows change", hold);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule